// File: doc/BRIEF.md
# Register Preload and Observe Test Controller

This block holds a bank of storage cells, each with two registers: a front register that normally drives the cell's output, and a hidden back register. Cells with an even index form the even half of the bank, and cells with an odd index form the odd half. In normal operation, both registers capture their data inputs on the clock when the run input is high. Each output shows the front register through a per-cell polarity control, gated by that cell's output enable.

Two test modes are provided for bring-up. Preload forces known levels into the registers, so a test can begin from any state. While preload is active, a rising edge on the load strobe copies the pin levels into one quarter of the bank. That quarter is one register kind (front or back) in one half (even or odd). Observe puts the raw back-register contents on the enabled outputs, which makes the hidden state visible. A lock input turns off both modes, and the block then behaves normally.

The strobe is sampled on the block clock. Its rising edge is found by comparing it with a one-cycle delayed copy.

Top module: `preload_observe_ctrl`

## Requirements
- R1: Asynchronous active-low reset clears every front and back register to 0. With all enables high, the output then reads all zeros when every polarity bit is 1 and all ones when every polarity bit is 0.
- R2: When preload is not active (mode low or lock high) and run is 1, each clock edge loads front register i from d1[i] and back register i from d2[i]. Output i equals oe[i] AND (pol_hi[i] ? front : NOT front).
- R3: When preload is active and a strobe rising edge is seen at a clock edge, the selected registers take pin_in levels at that edge. Selection: sel_back = 0 picks front registers and sel_back = 1 picks back registers. sel_odd = 0 picks cells with an even index and sel_odd = 1 picks cells with an odd index. A high pin loads 1 and a low pin loads 0.
- R4: While preload is active, every register outside the selected quarter keeps its value, and run has no effect.
- R5: The level loaded by preload does not depend on pol_hi.
- R6: A strobe held high loads only once. Pin changes after the first loading edge do not reach the registers until the strobe falls and rises again.
- R7: With observe active, preload inactive and lock low, output i equals oe[i] AND back register i, with no polarity applied.
- R8: With lock high, the strobe changes no register, run still captures normally, and the outputs show normal values even with observe requested.
- R9: If preload and observe are both requested, preload wins and the outputs show normal values.
- R10: out_en always equals oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Normal capture enable |
| pre_mode | input | 1 | Preload mode request |
| obs_mode | input | 1 | Observe mode request |
| lock | input | 1 | Security lock, blocks both modes |
| ld_stb | input | 1 | Preload strobe, acts on its rising edge |
| sel_back | input | 1 | 0 targets front registers, 1 targets back registers |
| sel_odd | input | 1 | 0 targets cells with an even index, 1 targets cells with an odd index |
| pin_in | input | NCELL | Levels to preload |
| d1 | input | NCELL | Normal data for the front registers |
| d2 | input | NCELL | Normal data for the back registers |
| oe | input | NCELL | Per-cell output enable |
| pol_hi | input | NCELL | Per-cell output polarity, 1 = active high |
| pin_out | output | NCELL | Cell output values |
| out_en | output | NCELL | Cell output enables |

## Verification
The hardest state to reach from the ports is a register that was left untouched next to a quarter that was just preloaded. The back registers can only be seen through observe mode, and normal capture overwrites everything as soon as preload ends. For this reason the bench keeps run low whenever it reads state back. It sweeps all four selections with polarity patterns that change from one pass to the next, and it moves the pins while the strobe is still held high. It then reads the front registers through the normal path and the back registers through observe mode, and compares both against a model that changes only the selected quarter.

// File: rtl/preload_observe_ctrl.sv
module preload_observe_ctrl #(
  parameter int NCELL = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_mode,
  input  logic             obs_mode,
  input  logic             lock,
  input  logic             ld_stb,
  input  logic             sel_back,
  input  logic             sel_odd,
  input  logic [NCELL-1:0] pin_in,
  input  logic [NCELL-1:0] d1,
  input  logic [NCELL-1:0] d2,
  input  logic [NCELL-1:0] oe,
  input  logic [NCELL-1:0] pol_hi,
  output logic [NCELL-1:0] pin_out,
  output logic [NCELL-1:0] out_en
);

  localparam int HALF = NCELL / 2;

  logic [NCELL-1:0] q1, q2;
  logic             stb_q;
  logic             pre_act, obs_act, fire;

  assign pre_act = pre_mode & ~lock;
  assign obs_act = obs_mode & ~lock & ~pre_mode;
  assign fire    = pre_act & ld_stb & ~stb_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= ld_stb;

  for (genvar h = 0; h < HALF; h++) begin : g_pair
    for (genvar k = 0; k < 2; k++) begin : g_cell
      localparam int IDX = 2 * h + k;
      logic r1, r2, hit;
      assign hit = fire & (sel_odd == (k == 1));

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          r1 <= 1'b0;
          r2 <= 1'b0;
        end else if (hit) begin
          if (!sel_back) r1 <= pin_in[IDX];
          else           r2 <= pin_in[IDX];
        end else if (run && !pre_act) begin
          r1 <= d1[IDX];
          r2 <= d2[IDX];
        end

      assign q1[IDX] = r1;
      assign q2[IDX] = r2;
    end
  end

  assign pin_out = oe & (obs_act ? q2 : ~(q1 ^ pol_hi));
  assign out_en  = oe;

endmodule

module preload_observe_chk #(
  parameter int NCELL = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             pre_mode,
  input logic             obs_mode,
  input logic             lock,
  input logic             ld_stb,
  input logic             sel_back,
  input logic             sel_odd,
  input logic [NCELL-1:0] pin_in,
  input logic [NCELL-1:0] d1,
  input logic [NCELL-1:0] d2,
  input logic [NCELL-1:0] oe,
  input logic [NCELL-1:0] pol_hi,
  input logic [NCELL-1:0] pin_out,
  input logic [NCELL-1:0] out_en,
  input logic [NCELL-1:0] q1,
  input logic [NCELL-1:0] q2
);

  logic             prev_stb;
  logic [NCELL-1:0] grp;
  logic             act, edge_now;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_stb <= 1'b0;
    else        prev_stb <= ld_stb;

  always_comb
    for (int i = 0; i < NCELL; i++) grp[i] = ((i % 2) == 1) == sel_odd;

  assign act      = pre_mode && !lock;
  assign edge_now = ld_stb && !prev_stb;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !act) |=> (q1 == $past(d1) && q2 == $past(d2)));

  a_r3_front_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edge_now && !sel_back) |=> ((q1 & $past(grp)) == ($past(pin_in) & $past(grp))));

  a_r3_back_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act && edge_now && sel_back) |=> ((q2 & $past(grp)) == ($past(pin_in) & $past(grp))));

  a_r4_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !sel_back) |=> (q2 == $past(q2)));

  a_r6_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !edge_now) |=> ($stable(q1) && $stable(q2)));

  a_r7_observe: assert property (@(posedge clk) disable iff (!rst_n)
    (obs_mode && !pre_mode && !lock) |-> (pin_out == (oe & q2)));

  a_r8_lock_normal: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (pin_out == (oe & ~(q1 ^ pol_hi))));

  a_r9_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_mode && obs_mode) |-> (pin_out == (oe & ~(q1 ^ pol_hi))));

  a_r10_enable: assert property (@(posedge clk) disable iff (!rst_n)
    out_en == oe);

endmodule

bind preload_observe_ctrl preload_observe_chk #(.NCELL(NCELL)) u_chk (.*);

// File: tb/preload_observe_ctrl_bench.sv
module preload_observe_ctrl_bench;
  localparam int N = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, pre_mode = 0, obs_mode = 0, lock = 0, ld_stb = 0, sel_back = 0, sel_odd = 0;
  logic [N-1:0] pin_in = '0, d1 = '0, d2 = '0, oe = '1, pol_hi = '1;
  logic [N-1:0] pin_out, out_en;
  logic [N-1:0] mq1 = '0, mq2 = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  preload_observe_ctrl #(.NCELL(N)) u_preload_observe_ctrl (.*);

  function automatic logic [N-1:0] expect_out();
    if (obs_mode && !pre_mode && !lock) return oe & mq2;
    return oe & ~(mq1 ^ pol_hi);
  endfunction

  function automatic logic [N-1:0] pat(int s);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ((i * 7 + s * 3) % 5) < 2;
    return v;
  endfunction

  task automatic chk(string req);
    logic [N-1:0] e;
    #1;
    e = expect_out();
    checks++;
    if (pin_out !== e) begin
      fails++;
      $display("FAIL %s pin_out=%h expected=%h", req, pin_out, e);
    end
    checks++;
    if (out_en !== oe) begin
      fails++;
      $display("FAIL R10 out_en=%h expected=%h", out_en, oe);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_back(string req);
    obs_mode = 0; chk(req);
    obs_mode = 1; chk(req);
    obs_mode = 0;
  endtask

  task automatic preload(int sel, int s, logic use_lock);
    logic [N-1:0] p;
    p = pat(s);
    lock = use_lock; pre_mode = 1; run = 1; sel_back = sel[1]; sel_odd = sel[0];
    pin_in = p; d1 = ~p; d2 = p ^ 24'h5A5A5A; pol_hi = pat(s + 11);
    ld_stb = 1;
    tick();
    if (use_lock) begin
      mq1 = d1; mq2 = d2;
    end else begin
      for (int i = 0; i < N; i++)
        if (((i % 2) == 1) == sel[0]) begin
          if (sel[1]) mq2[i] = p[i];
          else        mq1[i] = p[i];
        end
    end
    pin_in = ~p;
    tick();
    if (use_lock) begin
      mq1 = d1; mq2 = d2;
    end
    obs_mode = 1;
    chk("R9");
    obs_mode = 0;
    ld_stb = 0; run = 0;
    tick();
    pre_mode = 0; lock = 0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    pol_hi = '1; chk("R1");
    pol_hi = '0; chk("R1");
    rst_n = 1;
    tick();

    for (int s = 0; s < 4; s++) begin
      run = 1; d1 = pat(s); d2 = pat(s + 5); pol_hi = pat(s + 2); oe = ~pat(s + 9);
      tick();
      mq1 = d1; mq2 = d2;
      run = 0;
      chk("R2");
      obs_mode = 1; chk("R7");
      obs_mode = 0;
    end

    oe = '1;
    for (int s = 0; s < 3; s++)
      for (int sel = 0; sel < 4; sel++) begin
        preload(sel, s * 4 + sel, 1'b0);
        pol_hi = pat(sel + 1);
        read_back("R3 R4 R5 R6");
      end

    for (int sel = 0; sel < 4; sel++) begin
      preload(sel, 20 + sel, 1'b1);
      read_back("R8");
    end
    lock = 1; obs_mode = 1; pol_hi = pat(3);
    chk("R8");
    lock = 0; obs_mode = 0;

    pre_mode = 1; obs_mode = 1; oe = pat(7);
    chk("R9");
    pre_mode = 0; obs_mode = 0; oe = '1;

    rst_n = 0; #1;
    mq1 = '0; mq2 = '0;
    pol_hi = '1;
    read_back("R1");
    rst_n = 1;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule